// File: doc/BRIEF.md
# Configurable Stereo Serial Audio Receiver

This block turns a serial audio stream (bit clock, frame clock, data) into parallel stereo samples. Every completed left/right pair is shown on two 32-bit sample outputs with a one-cycle valid strobe. All serial pins are synchronised into and sampled on the system clock `clk`, which must run at least six times faster than the bit clock.

A small set of static controls lets one instance accept standard I2S, left-justified and right-justified streams at 16, 24 or 32 bits. The controls are:

- word-length code;
- justification;
- one-bit first-bit delay;
- bit-clock sampling edge;
- frame-clock level that marks the left channel;
- clock role.

As clock master the block generates the bit clock and frame clock itself. As slave it follows clocks supplied from outside. Captured words are sign-extended to 32 bits. A sticky overrun flag records a completed pair that arrived before the previous pair was acknowledged.

A four-state machine sequences capture:

| State | Meaning |
|---|---|
| `RX_OFF` | Disabled. |
| `RX_SEEK` | Waiting for the first frame-clock change, so that capture starts on a whole slot. |
| `RX_LEFT` | Filling the left slot. |
| `RX_RIGHT` | Filling the right slot. |

The transitions are:

- **start**: `RX_OFF` to `RX_SEEK` when both enables are high.
- **lock**: `RX_SEEK` to `RX_LEFT` or `RX_RIGHT` on the first frame-clock change, chosen by the new level.
- **left close**: `RX_LEFT` to `RX_RIGHT`; the left word is stored.
- **right close**: `RX_RIGHT` to `RX_LEFT`; the pair is emitted if a left word is held.
- **stop**: any state to `RX_OFF` when either enable drops.

Top module: `pcm_serial_rx`

## Requirements
- R1: `cfg_wlen` selects the captured word size: code 0 gives 16 bits, code 1 gives 24 bits, and codes 2 and 3 give 32 bits. The word is presented sign-extended from its top captured bit to 32 bits.
- R2: With `cfg_delay`=1, the bit sampled on the edge where the frame clock is first seen changed is the last bit of the old slot, and the new word's MSB is the next bit. With `cfg_delay`=0, the bit sampled on the change edge is the MSB of the new slot.
- R3: With `cfg_rjust`=1, the word is the last N bits of the slot, N being the configured word size. With `cfg_rjust`=0, it is the first N bits after the MSB position.
- R4: In slave mode, data and frame clock are sampled on the rising edge of `sck_in` when `cfg_bclk_inv`=0, and on its falling edge when `cfg_bclk_inv`=1.
- R5: A slot is left while the frame clock equals `cfg_left_high`, and right otherwise.
- R6: `pair_valid` is high for exactly one cycle per completed left-then-right pair. `left_sample` and `right_sample` change only in a cycle where `pair_valid` is high.
- R7: `overrun` is set when a pair completes while the previous pair is still unacknowledged (`pair_ack` not seen since it was shown). It then stays set while the block is enabled.
- R8: With `cfg_master`=1 and `glob_en`=1:
  - `clk_drive` is 1;
  - `sck_out` has a period of 2*HALF_DIV clock cycles;
  - `ws_out` toggles once every SLOT_BITS bit clocks;
  - capture uses these internal clocks.
- R9: While `glob_en` or `rx_en` is low, `pair_valid` stays low and `overrun` is cleared.
- R10: With `cfg_master`=0 or `glob_en`=0, `clk_drive` is 0, `sck_out` rests at `cfg_bclk_inv` and `ws_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global enable; also gates clock generation |
| rx_en | input | 1 | Receive enable |
| cfg_wlen | input | 2 | Word-length code (0:16, 1:24, 2/3:32) |
| cfg_rjust | input | 1 | 1 = right-justified capture |
| cfg_delay | input | 1 | 1 = MSB one bit clock after the frame change |
| cfg_bclk_inv | input | 1 | 1 = sample on the falling bit-clock edge |
| cfg_left_high | input | 1 | Frame-clock level that marks the left slot |
| cfg_master | input | 1 | 1 = generate the serial clocks |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External frame clock (slave) |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated frame clock |
| clk_drive | output | 1 | Output enable for `sck_out` and `ws_out` |
| left_sample | output | 32 | Left word of the last pair |
| right_sample | output | 32 | Right word of the last pair |
| pair_valid | output | 1 | One-cycle strobe for a new pair |
| pair_ack | input | 1 | Consumer acknowledges the shown pair |
| overrun | output | 1 | Sticky pair-lost flag |

## Verification
The properties assume the configuration inputs are held still while the receiver is enabled. The sign-extension check in particular relates the emitted word to `cfg_wlen` in the same and previous cycle. The bench changes configuration only with `rx_en` low.

The bench's serial model holds each bit-clock half for four system cycles. It changes data and frame clock only on the launch edge, so every value has settled through the two-stage synchroniser before the sampling edge. It re-enables the receiver between scenarios, so every stream begins with a whole right slot that the receiver can lock onto.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_SEEK  = 2'd1,
        RX_LEFT  = 2'd2,
        RX_RIGHT = 2'd3
    } rx_state_e;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 6;

    // word-length code to number of captured bits
    function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'd0:    n = CNT_W'(16);
            2'd1:    n = CNT_W'(24);
            default: n = CNT_W'(32);
        endcase
        return n;
    endfunction

    // replicate bit n-1 above the low n bits
    function automatic logic [WORD_W-1:0] sign_ext(input logic [WORD_W-1:0] raw,
                                                   input logic [CNT_W-1:0]  n);
        logic [WORD_W-1:0] res;
        logic              sgn;
        sgn = raw[n - CNT_W'(1)];
        for (int i = 0; i < WORD_W; i++) begin
            res[i] = (CNT_W'(i) < n) ? raw[i] : sgn;
        end
        return res;
    endfunction

endpackage

// File: rtl/pcm_rx_pin_sync.sv
module pcm_rx_pin_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic ws_raw,
    input  logic sd_raw,
    input  logic smp_fall,
    output logic smp_evt,
    output logic ws_sync,
    output logic sd_sync
);

    localparam int unsigned PINS = 3;

    logic [PINS-1:0] stage [SYNC_STAGES];
    logic            sck_prev;
    logic            sck_eff;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= {sck_raw, ws_raw, sd_raw};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign sck_eff = stage[SYNC_STAGES-1][2] ^ smp_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b1;
        else        sck_prev <= sck_eff;
    end

    assign smp_evt = sck_eff & ~sck_prev;
    assign ws_sync = stage[SYNC_STAGES-1][1];
    assign sd_sync = stage[SYNC_STAGES-1][0];

endmodule

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen #(
    parameter int unsigned HALF_DIV  = 4,
    parameter int unsigned SLOT_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck_gen,
    output logic ws_gen,
    output logic smp_evt
);

    localparam int unsigned DIV_W = (HALF_DIV  > 1) ? $clog2(HALF_DIV)  : 1;
    localparam int unsigned BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic             half_done;

    assign half_done = (div_cnt == DIV_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            sck_gen <= 1'b0;
            ws_gen  <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            sck_gen <= 1'b0;
            ws_gen  <= 1'b0;
        end else if (half_done) begin
            div_cnt <= '0;
            sck_gen <= ~sck_gen;
            if (sck_gen) begin
                // launch edge: advance the slot position
                if (bit_cnt == BIT_LAST) begin
                    bit_cnt <= '0;
                    ws_gen  <= ~ws_gen;
                end else begin
                    bit_cnt <= bit_cnt + BIT_W'(1);
                end
            end
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    assign smp_evt = run & half_done & ~sck_gen;

endmodule

// File: rtl/pcm_rx_slot_shifter.sv
module pcm_rx_slot_shifter
    import pcm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_evt,
    input  logic              slot_edge,
    input  logic              bit_val,
    input  logic              cfg_delay,
    input  logic              cfg_rjust,
    input  logic [CNT_W-1:0]  nbits,
    output logic [WORD_W-1:0] closing_word
);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              take;
    logic [WORD_W-1:0] appended;
    logic [WORD_W-1:0] closing_raw;
    logic [CNT_W-1:0]  cnt_inc;

    assign take        = cfg_rjust | (cnt < nbits);
    assign appended    = take ? {shreg[WORD_W-2:0], bit_val} : shreg;
    assign closing_raw = cfg_delay ? appended : shreg;
    assign cnt_inc     = (cnt == '1) ? cnt : cnt + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (bit_evt) begin
            if (slot_edge) begin
                if (cfg_delay) begin
                    shreg <= '0;
                    cnt   <= '0;
                end else begin
                    shreg <= {{(WORD_W-1){1'b0}}, bit_val};
                    cnt   <= CNT_W'(1);
                end
            end else begin
                shreg <= appended;
                cnt   <= cnt_inc;
            end
        end
    end

    assign closing_word = sign_ext(closing_raw, nbits);

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 4,
    parameter int unsigned SLOT_BITS   = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        glob_en,
    input  logic        rx_en,
    input  logic [1:0]  cfg_wlen,
    input  logic        cfg_rjust,
    input  logic        cfg_delay,
    input  logic        cfg_bclk_inv,
    input  logic        cfg_left_high,
    input  logic        cfg_master,
    input  logic        sck_in,
    input  logic        ws_in,
    input  logic        sd_in,
    output logic        sck_out,
    output logic        ws_out,
    output logic        clk_drive,
    output logic [31:0] left_sample,
    output logic [31:0] right_sample,
    output logic        pair_valid,
    input  logic        pair_ack,
    output logic        overrun
);

    rx_state_e         state_q, state_d;
    logic              run;
    logic              gen_run;
    logic              gen_sck, gen_ws, gen_evt;
    logic              ext_evt, ext_ws, ext_sd;
    logic              evt, ws_now;
    logic              ws_prev, primed;
    logic              slot_edge;
    logic              new_is_left;
    logic [CNT_W-1:0]  nbits;
    logic [WORD_W-1:0] closing_word;
    logic [WORD_W-1:0] left_hold;
    logic              have_left;
    logic              pending;

    assign run     = glob_en & rx_en;
    assign gen_run = glob_en & cfg_master;
    assign nbits   = wlen_bits(cfg_wlen);

    pcm_rx_clkgen #(
        .HALF_DIV  (HALF_DIV),
        .SLOT_BITS (SLOT_BITS)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gen_run),
        .sck_gen (gen_sck),
        .ws_gen  (gen_ws),
        .smp_evt (gen_evt)
    );

    pcm_rx_pin_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_raw  (sck_in),
        .ws_raw   (ws_in),
        .sd_raw   (sd_in),
        .smp_fall (cfg_bclk_inv),
        .smp_evt  (ext_evt),
        .ws_sync  (ext_ws),
        .sd_sync  (ext_sd)
    );

    // pick the clock source for capture
    assign evt    = cfg_master ? gen_evt : ext_evt;
    assign ws_now = cfg_master ? gen_ws  : ext_ws;

    assign clk_drive = gen_run;
    assign sck_out   = gen_run ? (gen_sck ^ cfg_bclk_inv) : cfg_bclk_inv;
    assign ws_out    = gen_run ? gen_ws : 1'b0;

    // frame-clock change tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev <= 1'b0;
            primed  <= 1'b0;
        end else if (!run) begin
            primed  <= 1'b0;
            ws_prev <= ws_now;
        end else if (evt) begin
            primed  <= 1'b1;
            ws_prev <= ws_now;
        end
    end

    assign slot_edge   = evt & primed & (ws_now != ws_prev);
    assign new_is_left = (ws_now == cfg_left_high);

    pcm_rx_slot_shifter u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (~run),
        .bit_evt      (evt),
        .slot_edge    (slot_edge),
        .bit_val      (ext_sd),
        .cfg_delay    (cfg_delay),
        .cfg_rjust    (cfg_rjust),
        .nbits        (nbits),
        .closing_word (closing_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_OFF: begin
                if (run) state_d = RX_SEEK;
            end
            RX_SEEK, RX_LEFT, RX_RIGHT: begin
                if (slot_edge) state_d = new_is_left ? RX_LEFT : RX_RIGHT;
            end
            default: state_d = RX_OFF;
        endcase
        if (!run) state_d = RX_OFF;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold    <= '0;
            have_left    <= 1'b0;
            pending      <= 1'b0;
            overrun      <= 1'b0;
            pair_valid   <= 1'b0;
            left_sample  <= '0;
            right_sample <= '0;
        end else if (!run) begin
            have_left  <= 1'b0;
            pending    <= 1'b0;
            overrun    <= 1'b0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (pair_ack) pending <= 1'b0;
            unique case (state_q)
                RX_LEFT: begin
                    if (slot_edge) begin
                        left_hold <= closing_word;
                        have_left <= 1'b1;
                    end
                end
                RX_RIGHT: begin
                    if (slot_edge && have_left) begin
                        left_sample  <= left_hold;
                        right_sample <= closing_word;
                        pair_valid   <= 1'b1;
                        have_left    <= 1'b0;
                        pending      <= 1'b1;
                        if (pending && !pair_ack) overrun <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        glob_en,
    input logic        rx_en,
    input logic [1:0]  cfg_wlen,
    input logic        cfg_master,
    input logic        clk_drive,
    input logic [31:0] left_sample,
    input logic [31:0] right_sample,
    input logic        pair_valid,
    input logic        overrun
);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R6
    samples_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_sample) && $stable(right_sample)));

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en || !rx_en) |=> !pair_valid);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && glob_en && rx_en) |=> overrun);

    // R1
    sext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && cfg_wlen == 2'd0 && $past(cfg_wlen) == 2'd0)
        |-> (left_sample[31:16] == {16{left_sample[15]}} &&
             right_sample[31:16] == {16{right_sample[15]}}));

    // R10
    drive_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_drive |-> (cfg_master && glob_en));

endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .glob_en      (glob_en),
    .rx_en        (rx_en),
    .cfg_wlen     (cfg_wlen),
    .cfg_master   (cfg_master),
    .clk_drive    (clk_drive),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .pair_valid   (pair_valid),
    .overrun      (overrun)
);

// File: tb/sim_pcm_serial_rx.sv
module sim_pcm_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glob_en = 1'b0;
    logic        rx_en = 1'b0;
    logic [1:0]  cfg_wlen = 2'd0;
    logic        cfg_rjust = 1'b0;
    logic        cfg_delay = 1'b1;
    logic        cfg_bclk_inv = 1'b0;
    logic        cfg_left_high = 1'b0;
    logic        cfg_master = 1'b0;
    logic        sck_in = 1'b1;
    logic        ws_in = 1'b1;
    logic        sd_in = 1'b0;
    logic        sck_out, ws_out, clk_drive;
    logic [31:0] left_sample, right_sample;
    logic        pair_valid;
    logic        pair_ack = 1'b0;
    logic        overrun;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic        auto_ack = 1'b1;
    int          rx_cnt   = 0;
    int          bad_pulse = 0;
    logic        prev_valid = 1'b0;
    logic [31:0] rx_l [32];
    logic [31:0] rx_r [32];
    logic [31:0] tx_l [4];
    logic [31:0] tx_r [4];

    always #10 clk = ~clk;

    pcm_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .rx_en(rx_en),
        .cfg_wlen(cfg_wlen), .cfg_rjust(cfg_rjust), .cfg_delay(cfg_delay),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_left_high(cfg_left_high),
        .cfg_master(cfg_master), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
        .sck_out(sck_out), .ws_out(ws_out), .clk_drive(clk_drive),
        .left_sample(left_sample), .right_sample(right_sample),
        .pair_valid(pair_valid), .pair_ack(pair_ack), .overrun(overrun)
    );

    // monitor: record pairs, answer with ack, watch pulse width
    always @(negedge clk) begin
        pair_ack <= pair_valid & auto_ack;
        if (pair_valid) begin
            rx_l[rx_cnt % 32] <= left_sample;
            rx_r[rx_cnt % 32] <= right_sample;
            rx_cnt <= rx_cnt + 1;
            if (prev_valid) bad_pulse <= bad_pulse + 1;
        end
        prev_valid <= pair_valid;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] sext(input logic [31:0] v, input int n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i < n) ? v[i] : v[n-1];
        return r;
    endfunction

    function automatic logic slot_bit(input logic [31:0] v, input int n,
                                      input logic rj, input int p);
        if (rj) return (p >= 32 - n) ? v[n - 1 - (p - (32 - n))] : 1'b0;
        return (p < n) ? v[n - 1 - p] : 1'b0;
    endfunction

    // serial transmitter model: dummy right slot, nfr pairs, dummy left slot
    task automatic play(input int nfr, input int n, input logic rj,
                        input logic dl, input logic inv, input logic lh);
        int slots;
        slots = 2 * nfr + 2;
        sck_in = ~inv;
        ws_in  = ~lh;
        repeat (8) @(negedge clk);
        for (int i = 0; i < slots * 32; i++) begin
            int s, p, sw, k;
            logic b;
            s  = i / 32;
            p  = i % 32;
            sw = (i + int'(dl)) / 32;
            if (sw > slots - 1) sw = slots - 1;
            if (s == 0 || s == slots - 1) b = 1'b0;
            else begin
                k = (s - 1) / 2;
                b = slot_bit((s % 2 == 1) ? tx_l[k] : tx_r[k], n, rj, p);
            end
            sck_in = inv;
            sd_in  = b;
            ws_in  = (sw % 2 == 1) ? lh : ~lh;
            repeat (4) @(negedge clk);
            sck_in = ~inv;
            repeat (4) @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] wl, input logic rj, input logic dl,
                         input logic inv, input logic lh);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        cfg_wlen = wl; cfg_rjust = rj; cfg_delay = dl;
        cfg_bclk_inv = inv; cfg_left_high = lh; cfg_master = 1'b0;
        glob_en = 1'b1;
        sck_in = ~inv;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
    endtask

    // one format scenario, two pairs, values compared sign-extended
    task automatic run_fmt(input string req, input logic [1:0] wl, input int n,
                           input logic rj, input logic dl, input logic inv, input logic lh);
        int base;
        setup(wl, rj, dl, inv, lh);
        base = rx_cnt;
        play(2, n, rj, dl, inv, lh);
        chk({req, " pair count"}, 32'(rx_cnt - base), 32'd2);
        for (int f = 0; f < 2; f++) begin
            chk({req, " left"},  rx_l[(base + f) % 32], sext(tx_l[f], n));
            chk({req, " right"}, rx_r[(base + f) % 32], sext(tx_r[f], n));
        end
        chk({req, " R7 no overrun when acked"}, 32'(overrun), 32'd0);
    endtask

    task automatic t_reset();
        chk("R6 reset valid", 32'(pair_valid), 32'd0);
        chk("R7 reset overrun", 32'(overrun), 32'd0);
        chk("R10 reset clk_drive", 32'(clk_drive), 32'd0);
        chk("R10 reset sck_out idle", 32'(sck_out), 32'(cfg_bclk_inv));
        chk("R10 reset ws_out", 32'(ws_out), 32'd0);
    endtask

    task automatic t_formats();
        tx_l[0] = 32'h0000_8001; tx_r[0] = 32'h0000_1234;
        tx_l[1] = 32'h0000_7FFE; tx_r[1] = 32'h0000_C3A5;
        run_fmt("R1 R2 i2s 16b", 2'd0, 16, 1'b0, 1'b1, 1'b0, 1'b0);
        tx_l[0] = 32'h007A_BCDE; tx_r[0] = 32'h0080_0001;
        tx_l[1] = 32'h00F0_0F0F; tx_r[1] = 32'h0012_3456;
        run_fmt("R1 R2 left-just 24b", 2'd1, 24, 1'b0, 1'b0, 1'b0, 1'b0);
        run_fmt("R3 right-just 24b", 2'd1, 24, 1'b1, 1'b0, 1'b0, 1'b0);
        tx_l[0] = 32'h8765_4321; tx_r[0] = 32'h0FED_CBA9;
        tx_l[1] = 32'hFFFF_0001; tx_r[1] = 32'h7000_000E;
        run_fmt("R1 i2s 32b", 2'd2, 32, 1'b0, 1'b1, 1'b0, 1'b0);
        tx_l[0] = 32'h0000_A5A5; tx_r[0] = 32'h0000_0F0F;
        tx_l[1] = 32'h0000_0001; tx_r[1] = 32'h0000_FFFF;
        run_fmt("R3 right-just 16b", 2'd0, 16, 1'b1, 1'b1, 1'b0, 1'b0);
        run_fmt("R4 falling-edge sampling", 2'd0, 16, 1'b0, 1'b1, 1'b1, 1'b0);
        run_fmt("R5 left on high frame clock", 2'd0, 16, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_overrun();
        auto_ack = 1'b0;
        setup(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        play(2, 16, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 overrun after unacked pair", 32'(overrun), 32'd1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 overrun cleared when disabled", 32'(overrun), 32'd0);
        auto_ack = 1'b1;
    endtask

    task automatic t_disabled();
        int base;
        setup(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        rx_en = 1'b0;
        base = rx_cnt;
        play(2, 16, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 no pairs while rx_en low", 32'(rx_cnt - base), 32'd0);
        chk("R10 slave clk_drive low", 32'(clk_drive), 32'd0);
    endtask

    task automatic t_master();
        int   cyc, rises, base, guard;
        logic ps, pw;
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        cfg_master = 1'b1; cfg_bclk_inv = 1'b0; cfg_wlen = 2'd0;
        cfg_delay = 1'b1; cfg_rjust = 1'b0; sd_in = 1'b1; glob_en = 1'b1;
        base = rx_cnt;
        rx_en = 1'b1;
        @(negedge clk);
        chk("R8 clk_drive high", 32'(clk_drive), 32'd1);
        // bit clock period
        ps = sck_out; guard = 0;
        while (!(sck_out && !ps) && guard < 100) begin
            ps = sck_out; @(negedge clk); guard++;
        end
        cyc = 0; ps = sck_out;
        do begin
            ps = sck_out; @(negedge clk); cyc++;
        end while (!(sck_out && !ps) && cyc < 100);
        chk("R8 sck period", 32'(cyc), 32'd8);
        // bit clocks per frame-clock level
        pw = ws_out; guard = 0;
        while (ws_out == pw && guard < 2000) begin @(negedge clk); guard++; end
        pw = ws_out; rises = 0; ps = sck_out; guard = 0;
        while (ws_out == pw && guard < 2000) begin
            ps = sck_out; @(negedge clk); guard++;
            if (sck_out && !ps) rises++;
        end
        chk("R8 bits per frame level", 32'(rises), 32'd32);
        guard = 0;
        while (rx_cnt == base && guard < 4000) begin @(negedge clk); guard++; end
        chk("R8 master capture left", rx_l[base % 32], 32'hFFFF_FFFF);
        chk("R8 master capture right", rx_r[base % 32], 32'hFFFF_FFFF);
        glob_en = 1'b0;
        @(negedge clk);
        chk("R10 clocks released when globally disabled", 32'(clk_drive), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_formats();
        t_overrun();
        t_disabled();
        t_master();
        chk("R6 single-cycle valid pulses", 32'(bad_pulse), 32'd0);
        report();
    end

endmodule